// File: doc/BRIEF.md
# Frame-Transfer Sensor Gate Sequencer

This block generates the digital control levels for the gates of a frame-transfer image sensor. A downstream level-shifting driver turns these levels into analog drive. The block repeats the same field sequence without stopping. The field opens with an integration phase, in which the antiblooming gate gets a short pulse burst at the start of every horizontal line. An optional fast clear can interrupt integration partway through, and this sets the start of the electronic shutter. The whole image area is then moved into storage. Readout follows, one line at a time: a single storage-gate shift loads the next stored line into the serial register, and a train of serial-gate pulses then reads that line out pixel by pixel.

While the serial pulses run, one-hot pixel-class flags mark each pixel as a leading dummy cell, an optically shielded dark-reference cell, an active pixel or the trailing buffer column. A black-level clamp can key on the dark flag. A line-valid level spans the serial pulses of each line, and a one-cycle strobe marks the first cycle of every field.

The shutter input gives the integration line at which the fast clear runs. It is sampled once, at field start. Every gate pulse is one clock high followed by one clock low, so a 25 MHz clock gives an 80 ns pixel period.

Top module: `ft_ccd_seq`

## Requirements
- R1: While reset is asserted, and up to the first field strobe, every gate output, line_valid, frame_start and every pixel flag is low.
- R2: frame_start is high for exactly one cycle at the start of each field. Successive strobes are exactly one field length apart. shutter_line is sampled only in the cycle that produces the strobe, so a change made later in the field has no effect on that field.
- R3: Integration lasts INT_LINES lines of HLINE_CYC cycles each. Every line begins with ABG_PULSES pulses on abg_gate, each one cycle high and one cycle low. abg_gate is never high while any other gate is high, and never high outside integration.
- R4: If shutter_line is a value S with 0 < S < INT_LINES, then after integration line S-1 the block emits LINES pulses on img_gate with stor_gate low. Integration then resumes at line S, so S×ABG_PULSES bursts come before the clear and (INT_LINES−S)×ABG_PULSES come after it. A value of 0, or any value of INT_LINES or more, gives no clear.
- R5: After integration, img_gate and stor_gate pulse together exactly LINES times.
- R6: Each readout line is one stor_gate pulse with img_gate low and line_valid low, followed by exactly TOTAL_PIX = PIX_DUMMY+PIX_DARK+PIX_ACTIVE+PIX_BUF ser_gate pulses, all inside line_valid.
- R7: Each field has exactly LINES readout lines. The field length is INT_LINES×HLINE_CYC + 2×LINES + LINES×(2+2×TOTAL_PIX) cycles, plus 2×LINES when a clear runs.
- R8: Within each line, the pixel flags mark the pixels in a fixed order: PIX_DUMMY dummy, then PIX_DARK dark, then PIX_ACTIVE active, then PIX_BUF buffer. Exactly one flag is high for each serial pulse.
- R9: No pixel flag is high outside line_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, two cycles per gate pulse |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shutter_line | input | $clog2(INT_LINES) | Integration line at which the fast clear runs; 0 disables it |
| img_gate | output | 1 | Image-area gate level (both image gates) |
| stor_gate | output | 1 | Storage-area gate level |
| ser_gate | output | 1 | Serial-register gate level |
| abg_gate | output | 1 | Antiblooming gate level |
| line_valid | output | 1 | High across the serial pulses of one readout line |
| frame_start | output | 1 | One-cycle strobe at the first cycle of each field |
| pix_dummy | output | 1 | Current pixel is a leading dummy cell |
| pix_dark | output | 1 | Current pixel is a shielded dark-reference cell |
| pix_active | output | 1 | Current pixel is an active pixel |
| pix_buf | output | 1 | Current pixel is the trailing buffer column |

## Verification
The ordering properties assume that each pixel class has at least one member, and the bench builds the block with small nonzero counts of every class. They also assume shutter_line is steady in the cycle of the field strobe. Scenarios change the shutter value only right after a strobe has been seen, except for one deliberate change in the middle of a field, which must be ignored. The bench applies shutter values at both in-range extremes and one out-of-range value, and reconstructs each field from the gate edges alone.

// File: rtl/ftseq_pkg.sv
package ftseq_pkg;
  typedef enum logic [2:0] {
    ST_INTEG,
    ST_CLEAR,
    ST_XFER,
    ST_SHIFT,
    ST_READ
  } seq_st_e;

  // bit positions of the one-hot pixel-class vector
  localparam int PX_DUMMY  = 0;
  localparam int PX_DARK   = 1;
  localparam int PX_ACTIVE = 2;
  localparam int PX_BUF    = 3;
endpackage

// File: rtl/ftseq_pixclass.sv
module ftseq_pixclass #(
  parameter int PIX_DUMMY  = 2,
  parameter int PIX_DARK   = 12,
  parameter int PIX_ACTIVE = 324,
  parameter int IW         = 9
) (
  input  logic [IW-1:0] idx,
  output logic [3:0]    cls
);
  import ftseq_pkg::*;

  localparam logic [IW-1:0] END_DUMMY = IW'(PIX_DUMMY);
  localparam logic [IW-1:0] END_DARK  = IW'(PIX_DUMMY + PIX_DARK);
  localparam logic [IW-1:0] END_ACT   = IW'(PIX_DUMMY + PIX_DARK + PIX_ACTIVE);

  always_comb begin
    cls = '0;
    if (idx < END_DUMMY)     cls[PX_DUMMY]  = 1'b1;
    else if (idx < END_DARK) cls[PX_DARK]   = 1'b1;
    else if (idx < END_ACT)  cls[PX_ACTIVE] = 1'b1;
    else                     cls[PX_BUF]    = 1'b1;
  end
endmodule

// File: rtl/ftseq_abg_burst.sv
module ftseq_abg_burst #(
  parameter int ABG_PULSES = 4,
  parameter int HW         = 11
) (
  input  logic          en,
  input  logic [HW-1:0] pos,
  output logic          pulse
);
  localparam logic [HW:0] BURST_LEN = (HW+1)'(2 * ABG_PULSES);

  // high on even positions inside the blanking window at line start
  always_comb pulse = en && ({1'b0, pos} < BURST_LEN) && !pos[0];
endmodule

// File: rtl/ft_ccd_seq.sv
module ft_ccd_seq #(
  parameter int LINES      = 244,
  parameter int PIX_DUMMY  = 2,
  parameter int PIX_DARK   = 12,
  parameter int PIX_ACTIVE = 324,
  parameter int PIX_BUF    = 1,
  parameter int INT_LINES  = 262,
  parameter int HLINE_CYC  = 1590,
  parameter int ABG_PULSES = 4,
  localparam int SHW       = $clog2(INT_LINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SHW-1:0] shutter_line,
  output logic           img_gate,
  output logic           stor_gate,
  output logic           ser_gate,
  output logic           abg_gate,
  output logic           line_valid,
  output logic           frame_start,
  output logic           pix_dummy,
  output logic           pix_dark,
  output logic           pix_active,
  output logic           pix_buf
);
  import ftseq_pkg::*;

  localparam int TOTAL_PIX = PIX_DUMMY + PIX_DARK + PIX_ACTIVE + PIX_BUF;
  localparam int MAX_LN    = (INT_LINES > LINES) ? INT_LINES : LINES;
  localparam int MAX_STP   = (TOTAL_PIX > LINES) ? TOTAL_PIX : LINES;
  localparam int LCW       = $clog2(MAX_LN + 1);
  localparam int SCW       = $clog2(MAX_STP + 1);
  localparam int HW        = $clog2(HLINE_CYC + 1);
  localparam logic [LCW-1:0] INT_LAST = LCW'(INT_LINES - 1);
  localparam logic [LCW-1:0] RD_LAST  = LCW'(LINES - 1);
  localparam logic [SCW-1:0] XF_LAST  = SCW'(LINES - 1);
  localparam logic [SCW-1:0] PX_LAST  = SCW'(TOTAL_PIX - 1);
  localparam logic [HW-1:0]  CYC_LAST = HW'(HLINE_CYC - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  assign rst_i_n = rst_sync[1];

  seq_st_e        st, st_n;
  logic           ph, ph_n;
  logic [SCW-1:0] stp, stp_n;
  logic [LCW-1:0] ln, ln_n, ln_inc;
  logic [HW-1:0]  cyc, cyc_n;
  logic [SHW-1:0] sh_q, sh_n;
  logic [3:0]     cls;
  logic           abg_n;

  assign ln_inc = ln + 1'b1;

  ftseq_pixclass #(
    .PIX_DUMMY(PIX_DUMMY), .PIX_DARK(PIX_DARK), .PIX_ACTIVE(PIX_ACTIVE), .IW(SCW)
  ) u_cls (.idx(stp), .cls(cls));

  ftseq_abg_burst #(.ABG_PULSES(ABG_PULSES), .HW(HW)) u_abg (
    .en(st == ST_INTEG), .pos(cyc), .pulse(abg_n)
  );

  // next-state logic
  always_comb begin
    st_n  = st;
    ph_n  = ph;
    stp_n = stp;
    ln_n  = ln;
    cyc_n = cyc;
    sh_n  = sh_q;
    case (st)
      ST_INTEG: begin
        if (ln == '0 && cyc == '0) sh_n = shutter_line;
        if (cyc == CYC_LAST) begin
          cyc_n = '0;
          ph_n  = 1'b0;
          stp_n = '0;
          if (ln == INT_LAST) begin
            st_n = ST_XFER;
            ln_n = '0;
          end else begin
            ln_n = ln_inc;
            if (sh_q != '0 && LCW'(sh_q) == ln_inc) st_n = ST_CLEAR;
          end
        end else begin
          cyc_n = cyc + 1'b1;
        end
      end
      ST_CLEAR, ST_XFER: begin
        ph_n = ~ph;
        if (ph) begin
          if (stp == XF_LAST) begin
            stp_n = '0;
            st_n  = (st == ST_CLEAR) ? ST_INTEG : ST_SHIFT;
          end else begin
            stp_n = stp + 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        ph_n = ~ph;
        if (ph) st_n = ST_READ;
      end
      ST_READ: begin
        ph_n = ~ph;
        if (ph) begin
          if (stp == PX_LAST) begin
            stp_n = '0;
            if (ln == RD_LAST) begin
              st_n  = ST_INTEG;
              ln_n  = '0;
              cyc_n = '0;
            end else begin
              st_n = ST_SHIFT;
              ln_n = ln_inc;
            end
          end else begin
            stp_n = stp + 1'b1;
          end
        end
      end
      default: st_n = ST_INTEG;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n)
    if (!rst_i_n) begin
      st   <= ST_INTEG;
      ph   <= 1'b0;
      stp  <= '0;
      ln   <= '0;
      cyc  <= '0;
      sh_q <= '0;
    end else begin
      st   <= st_n;
      ph   <= ph_n;
      stp  <= stp_n;
      ln   <= ln_n;
      cyc  <= cyc_n;
      sh_q <= sh_n;
    end

  // registered, glitch-free outputs
  always_ff @(posedge clk or negedge rst_i_n)
    if (!rst_i_n) begin
      img_gate    <= 1'b0;
      stor_gate   <= 1'b0;
      ser_gate    <= 1'b0;
      abg_gate    <= 1'b0;
      line_valid  <= 1'b0;
      frame_start <= 1'b0;
      pix_dummy   <= 1'b0;
      pix_dark    <= 1'b0;
      pix_active  <= 1'b0;
      pix_buf     <= 1'b0;
    end else begin
      img_gate    <= !ph && (st == ST_CLEAR || st == ST_XFER);
      stor_gate   <= !ph && (st == ST_XFER || st == ST_SHIFT);
      ser_gate    <= !ph && (st == ST_READ);
      abg_gate    <= abg_n;
      line_valid  <= (st == ST_READ);
      frame_start <= (st == ST_INTEG) && ln == '0 && cyc == '0;
      pix_dummy   <= (st == ST_READ) && cls[PX_DUMMY];
      pix_dark    <= (st == ST_READ) && cls[PX_DARK];
      pix_active  <= (st == ST_READ) && cls[PX_ACTIVE];
      pix_buf     <= (st == ST_READ) && cls[PX_BUF];
    end

  // assertions
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_i_n)
    frame_start |=> !frame_start);
  a_r3_abg_isolated: assert property (@(posedge clk) disable iff (!rst_i_n)
    abg_gate |-> !(img_gate || stor_gate || ser_gate || line_valid));
  a_r4_clear_outside_line: assert property (@(posedge clk) disable iff (!rst_i_n)
    (img_gate && !stor_gate) |-> !line_valid);
  a_r6_ser_in_line: assert property (@(posedge clk) disable iff (!rst_i_n)
    ser_gate |-> line_valid);
  a_r6_shift_outside_line: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stor_gate && !img_gate) |-> !line_valid);
  a_r8_flags_onehot: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({pix_dummy, pix_dark, pix_active, pix_buf}));
  a_r8_dark_after_dummy: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(pix_dark) |-> $past(pix_dummy));
  a_r8_active_after_dark: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(pix_active) |-> $past(pix_dark));
  a_r8_buf_after_active: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(pix_buf) |-> $past(pix_active));
  a_r9_flags_in_line: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pix_dummy || pix_dark || pix_active || pix_buf) |-> line_valid);
endmodule

// File: tb/ft_ccd_seq_tb.sv
module ft_ccd_seq_tb;
  localparam int LINES = 5, DUM = 2, DARK = 3, ACT = 4, BUF = 1;
  localparam int INTL = 6, HCYC = 16, ABGP = 3;
  localparam int TOT = DUM + DARK + ACT + BUF;
  localparam int BASE_LEN = INTL*HCYC + 2*LINES + LINES*(2 + 2*TOT);
  localparam int SHW = $clog2(INTL);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SHW-1:0] shutter_line = '0;
  logic img_gate, stor_gate, ser_gate, abg_gate, line_valid, frame_start;
  logic pix_dummy, pix_dark, pix_active, pix_buf;

  always #2 clk = ~clk;

  ft_ccd_seq #(.LINES(LINES), .PIX_DUMMY(DUM), .PIX_DARK(DARK), .PIX_ACTIVE(ACT),
    .PIX_BUF(BUF), .INT_LINES(INTL), .HLINE_CYC(HCYC), .ABG_PULSES(ABGP)) u_dut (
    .clk(clk), .rst_n(rst_n), .shutter_line(shutter_line),
    .img_gate(img_gate), .stor_gate(stor_gate), .ser_gate(ser_gate),
    .abg_gate(abg_gate), .line_valid(line_valid), .frame_start(frame_start),
    .pix_dummy(pix_dummy), .pix_dark(pix_dark), .pix_active(pix_active), .pix_buf(pix_buf));

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-field observations
  int f_len, f_fs, f_abg, f_abg_pre, f_clr, f_xfer, f_shift, f_lines, f_badlen;
  int f_order, f_overlap, f_stray, f_hot;
  int f_cls[4];

  task automatic sync_field();
    @(negedge clk);
    while (!frame_start) @(negedge clk);
  endtask

  // called at the negedge where frame_start is seen; returns at the next one
  task automatic observe_field(input bit mid_change, input logic [SHW-1:0] mid_val);
    logic p_abg = 1'b0, p_img = 1'b0, p_stor = 1'b0, p_ser = 1'b0, p_lv = 1'b0;
    int ser_cnt = 0, last_cls = 0;
    bit in_line = 1'b0;
    f_len = 0; f_fs = 0; f_abg = 0; f_abg_pre = -1; f_clr = 0; f_xfer = 0;
    f_shift = 0; f_lines = 0; f_badlen = 0; f_order = 0; f_overlap = 0;
    f_stray = 0; f_hot = 0;
    for (int k = 0; k < 4; k++) f_cls[k] = 0;
    do begin
      f_len++;
      if (mid_change && f_len == 20) shutter_line = mid_val;
      if (frame_start) f_fs++;
      if (abg_gate && !p_abg) f_abg++;
      if (abg_gate && (img_gate || stor_gate || ser_gate || line_valid)) f_overlap++;
      if (img_gate && !p_img && !stor_gate) begin
        if (f_clr == 0) f_abg_pre = f_abg;
        f_clr++;
      end
      if (img_gate && !p_img && stor_gate) f_xfer++;
      if (stor_gate && !p_stor && !img_gate) f_shift++;
      if ((pix_dummy || pix_dark || pix_active || pix_buf) && !line_valid) f_stray++;
      if (line_valid && !p_lv) begin
        f_lines++; in_line = 1'b1; ser_cnt = 0; last_cls = 0;
      end
      if (!line_valid && p_lv && in_line) begin
        if (ser_cnt != TOT) f_badlen++;
        in_line = 1'b0;
      end
      if (ser_gate && !p_ser) begin
        int c;
        ser_cnt++;
        if ($countones({pix_dummy, pix_dark, pix_active, pix_buf}) != 1) f_hot++;
        c = pix_buf ? 3 : pix_active ? 2 : pix_dark ? 1 : 0;
        if (c < last_cls) f_order++;
        last_cls = c;
        f_cls[c]++;
      end
      p_abg = abg_gate; p_img = img_gate; p_stor = stor_gate; p_ser = ser_gate;
      p_lv = line_valid;
      @(negedge clk);
    end while (!frame_start);
    if (in_line && ser_cnt != TOT) f_badlen++;
  endtask

  task automatic check_common(input int exp_len);
    chk(f_fs == 1, "R2 strobe width", f_fs, 1);
    chk(f_len == exp_len, "R7 field length", f_len, exp_len);
    chk(f_abg == INTL*ABGP, "R3 abg pulse total", f_abg, INTL*ABGP);
    chk(f_overlap == 0, "R3 abg overlap", f_overlap, 0);
    chk(f_xfer == LINES, "R5 transfer pulses", f_xfer, LINES);
    chk(f_shift == LINES, "R6 line shifts", f_shift, LINES);
    chk(f_badlen == 0, "R6 serial pulses per line", f_badlen, 0);
    chk(f_lines == LINES, "R7 readout lines", f_lines, LINES);
    chk(f_order == 0 && f_hot == 0, "R8 flag order", f_order + f_hot, 0);
    chk(f_cls[0] == LINES*DUM, "R8 dummy count", f_cls[0], LINES*DUM);
    chk(f_cls[1] == LINES*DARK, "R8 dark count", f_cls[1], LINES*DARK);
    chk(f_cls[2] == LINES*ACT, "R8 active count", f_cls[2], LINES*ACT);
    chk(f_cls[3] == LINES*BUF, "R8 buffer count", f_cls[3], LINES*BUF);
    chk(f_stray == 0, "R9 flags outside line", f_stray, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({img_gate, stor_gate, ser_gate, abg_gate, line_valid, frame_start,
         pix_dummy, pix_dark, pix_active, pix_buf} == '0, "R1 outputs in reset",
        int'({img_gate, stor_gate, ser_gate, abg_gate, line_valid, frame_start}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({img_gate, stor_gate, ser_gate, abg_gate, line_valid} == '0,
        "R1 outputs after release",
        int'({img_gate, stor_gate, ser_gate, abg_gate, line_valid}), 0);
  endtask

  task automatic t_no_shutter(input logic [SHW-1:0] s, input string tag);
    shutter_line = s;
    sync_field();
    observe_field(1'b0, '0);
    check_common(BASE_LEN);
    chk(f_clr == 0, {"R4 no clear ", tag}, f_clr, 0);
  endtask

  task automatic t_shutter(input int s, input bit mid_change);
    shutter_line = SHW'(s);
    sync_field();
    observe_field(mid_change, '0);
    check_common(BASE_LEN + 2*LINES);
    chk(f_clr == LINES, "R4 clear pulses", f_clr, LINES);
    chk(f_abg_pre == s*ABGP, "R4 bursts before clear", f_abg_pre, s*ABGP);
    chk(f_abg - f_abg_pre == (INTL-s)*ABGP, "R4 bursts after clear",
        f_abg - f_abg_pre, (INTL-s)*ABGP);
    if (mid_change) chk(f_clr == LINES, "R2 mid-field change ignored", f_clr, LINES);
  endtask

  initial begin
    t_reset();
    t_no_shutter('0, "zero");
    t_shutter(1, 1'b0);
    t_shutter(INTL-1, 1'b0);
    t_no_shutter(SHW'(7), "out of range");
    t_shutter(3, 1'b1);
    t_no_shutter('0, "after change");
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule